// File: doc/BRIEF.md
# Ripple Maximum Selector

This block returns the larger of two unsigned operands. It is built from a chain of identical one-bit scan cells. The chain starts at the most significant bit and runs toward the least significant bit. Each cell gets its two operand bits and a small scan state from the cell above it. From these it forms its own bit of the result at once, and it passes an updated scan state down to the next cell. No separate comparator drives a wide multiplexer. The longest path is a single walk from the top bit to the bottom bit.

The scan state has two flags. The first says that every bit seen so far has matched. The second says that operand A won, and it means something only once a mismatch has been found. The top cell starts with "matched" set and "A won" clear. An output flag reports whether A was the chosen operand, and it reports A when the operands are equal. A parameter can add a single output register stage. That stage has a synchronous active-high reset and a valid bit that travels alongside the data.

Top module: `maxrip_top`

## Requirements
- R1: `out_max` equals the larger of `op_a` and `op_b`, both taken as unsigned `W`-bit numbers.
- R2: When `op_a == op_b`, `out_max` equals that common value and `out_sel_a` is 1.
- R3: `out_sel_a` is 1 when `op_a > op_b` or the operands are equal, and 0 when `op_a < op_b`.
- R4: The highest bit position where the operands differ decides the result. The operand holding a 1 there is chosen, whatever the lower bits hold. This includes operands that differ only in bit `W-1` or only in bit 0.
- R5: With `REG_OUT=1` (the default), the result for inputs sampled at one rising clock edge appears on the outputs after that same edge. It stays there until the next edge.
- R6: `out_valid` shows the value `in_valid` had at the previous rising edge. While `rst` is 1 at a rising edge, that edge sets `out_valid`, `out_max` and `out_sel_a` to 0.
- R7: At an edge where `in_valid` is 0 (and `rst` is 0), `out_max` and `out_sel_a` keep their previous values.
- R8: `out_max` is always bit-for-bit equal to one of the two operands. It is never a mix of bits from both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be taken |
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| out_valid | output | 1 | `out_max`/`out_sel_a` carry a new result |
| out_max | output | W | Larger operand |
| out_sel_a | output | 1 | 1 when `op_a` was chosen (including a tie) |

## Verification
The hardest case to reach is the one where the "matched" flag has to travel through most of the chain. This happens when the operands share a long upper prefix and first differ low down, with lower bits that would point the other way. Random operands almost never do this, because they nearly always differ in the top few bits. So the stimulus walks a single deciding bit position through every index. The bits above that position are kept equal, the bits below it are random, and either operand can be the winner. On top of this come directed operand pairs: a tie, all zeros, all ones, a difference only in the top bit, and a difference only in the bottom bit.

// File: rtl/maxrip_pkg.sv
package maxrip_pkg;

  // Scan state passed from one bit cell to the next lower one
  typedef struct packed {
    logic same;    // all higher bits matched
    logic a_wins;  // A holds the 1 at the first mismatch (valid when !same)
  } scan_t;

  localparam scan_t SCAN_START = '{same: 1'b1, a_wins: 1'b0};

endpackage

// File: rtl/maxrip_cell.sv
module maxrip_cell
  import maxrip_pkg::*;
(
  input  logic  a_bit,
  input  logic  b_bit,
  input  scan_t scan_in,
  output logic  r_bit,
  output scan_t scan_out
);

  logic differ;

  always_comb begin
    differ            = a_bit ^ b_bit;
    scan_out.same     = scan_in.same & ~differ;
    scan_out.a_wins   = scan_in.same ? (a_bit & ~b_bit) : scan_in.a_wins;
    if (scan_in.same)
      r_bit = a_bit | b_bit;
    else
      r_bit = scan_in.a_wins ? a_bit : b_bit;
  end

endmodule

// File: rtl/maxrip_chain.sv
module maxrip_chain
  import maxrip_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mx,
  output logic         pick_a
);

  // scan[W] feeds the top cell, scan[0] leaves the bottom cell
  scan_t scan [W+1];

  assign scan[W] = SCAN_START;

  for (genvar i = W - 1; i >= 0; i--) begin : g_cell
    maxrip_cell u_cell (
      .a_bit   (a[i]),
      .b_bit   (b[i]),
      .scan_in (scan[i+1]),
      .r_bit   (mx[i]),
      .scan_out(scan[i])
    );
  end

  assign pick_a = scan[0].same | scan[0].a_wins;

endmodule

// File: rtl/maxrip_outreg.sv
module maxrip_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d_max,
  input  logic         d_sel,
  output logic         q_valid,
  output logic [W-1:0] q_max,
  output logic         q_sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_max   <= '0;
      q_sel   <= 1'b0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_max <= d_max;
        q_sel <= d_sel;
      end
    end
  end

endmodule

// File: rtl/maxrip_top.sv
module maxrip_top #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] out_max,
  output logic         out_sel_a
);

  logic [W-1:0] c_max;
  logic         c_sel;

  maxrip_chain #(.W(W)) u_chain (
    .a     (op_a),
    .b     (op_b),
    .mx    (c_max),
    .pick_a(c_sel)
  );

  if (REG_OUT) begin : g_reg
    maxrip_outreg #(.W(W)) u_oreg (
      .clk    (clk),
      .rst    (rst),
      .d_valid(in_valid),
      .d_max  (c_max),
      .d_sel  (c_sel),
      .q_valid(out_valid),
      .q_max  (out_max),
      .q_sel  (out_sel_a)
    );

    // R1
    max_bound_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_max >= $past(op_a) && out_max >= $past(op_b)));
    // R3
    sel_dir_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_sel_a == ($past(op_a) >= $past(op_b))));
    // R8
    whole_operand_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_max == $past(op_a) || out_max == $past(op_b)));
    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_max) && $stable(out_sel_a)));
    // R6
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && out_max == '0 && !out_sel_a));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_max   = c_max;
    assign out_sel_a = c_sel;

    // R1
    max_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (out_max >= op_a && out_max >= op_b));
    // R8
    whole_operand_chk: assert property (@(posedge clk) disable iff (rst)
      (out_max == op_a || out_max == op_b));
    // R3
    sel_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (out_sel_a == (op_a >= op_b)));
  end

endmodule

// File: tb/sim_maxrip_top.sv
module sim_maxrip_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         out_valid;
  logic [W-1:0] out_max;
  logic         out_sel_a;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  maxrip_top #(.W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_max(out_max), .out_sel_a(out_sel_a)
  );

  // behavioural reference, one register stage
  logic         m_valid = 1'b0;
  logic [W-1:0] m_max   = '0;
  logic         m_sel   = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0; m_max <= '0; m_sel <= 1'b0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_max <= (op_a > op_b) ? op_a : op_b;
        m_sel <= (op_a >= op_b);
      end
    end
  end

  task automatic compare(input string tag);
    n_run++;
    if (out_valid !== m_valid || out_max !== m_max || out_sel_a !== m_sel) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b max=%h sel=%0b, expected valid=%0b max=%h sel=%0b",
               tag, out_valid, out_max, out_sel_a, m_valid, m_max, m_sel);
    end
  endtask

  // drive on falling edge, let one rising edge pass, check on next falling edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic v, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = v;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    logic [W-1:0] x, lo_a, lo_b, ta, tb_v;
    // R6: reset state while valid is driven high
    in_valid = 1'b1; op_a = 16'h1234; op_b = 16'h0042;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R6 reset clears outputs");
    rst = 1'b0;

    step(16'hABCD, 16'hABCD, 1, "R2 equal operands");
    step(16'h0000, 16'h0000, 1, "R2 all zeros");
    step(16'hFFFF, 16'hFFFF, 1, "R2 all ones");
    step(16'h8000, 16'h0000, 1, "R4 MSB only, a larger");
    step(16'h7FFF, 16'hFFFF, 1, "R4 MSB only, b larger");
    step(16'h0001, 16'h0000, 1, "R4 LSB only, a larger");
    step(16'hFFFE, 16'hFFFF, 1, "R4 LSB only, b larger");
    step(16'h00FF, 16'h0100, 1, "R3 b larger, low bits favour a");
    step(16'hFFFF, 16'h0000, 1, "R1 extremes");
    step(16'h0000, 16'hFFFF, 1, "R1 extremes swapped");

    // R7: idle edges keep previous result despite new operands
    step(16'h5555, 16'hAAAA, 0, "R7 hold when idle");
    step(16'hFFFF, 16'h0001, 0, "R7 hold when idle again");
    // R5: one result per edge, back to back
    step(16'h0003, 16'h0002, 1, "R5 back-to-back first");
    step(16'h0002, 16'h0003, 1, "R5 back-to-back second");

    // R4: walk the deciding bit through every position
    for (int k = 0; k < W; k++) begin
      for (int w = 0; w < 2; w++) begin
        x    = W'($urandom);
        lo_a = W'($urandom);
        lo_b = W'($urandom);
        ta = x; tb_v = x;
        for (int j = 0; j < k; j++) begin
          ta[j] = lo_a[j]; tb_v[j] = lo_b[j];
        end
        ta[k] = (w == 0); tb_v[k] = (w != 0);
        step(ta, tb_v, 1, "R4 deciding bit walk");
      end
    end

    // R1 R3 R8 random operands, random valid
    for (int n = 0; n < 400; n++) begin
      step(W'($urandom), W'($urandom), ($urandom % 4) != 0, "R1/R3/R8 random");
    end

    // R6: reset mid-stream
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    compare("R6 reset mid-stream");
    rst = 1'b0;
    step(16'h1000, 16'h0FFF, 1, "R1 after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule